// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block holds the control address register of a microprogrammed control unit and works out, once per enabled clock, which control-store word is fetched next. Each cycle it receives the sequencing part of the current microinstruction. That part carries a three-bit next-address operation, a branch target and a condition select. The block also receives a vector of status flags and the opcode of the machine instruction being executed. The register value leaves the block on `car` and addresses a control store that sits outside it.

Apart from the increment, no address is computed with an adder. Every other change of address is one of the following: a full replacement by the target, an OR of target bits into the low part of the register, a value formed from the opcode, or a value popped from a small dedicated return-address stack. The opcode can be turned into a routine address in three ways. It can be placed above a field of zeros, which gives fixed-size routine segments. It can be placed below a field of zeros, which gives a jump table in low memory. Or it can be looked up in a 16-entry decode table that is loaded through a write port.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The `en` input is the only way to stall the sequencer.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `car` to 0, empties the return stack, and clears `stk_ovf` and `stk_unf`.
- R2: While `en` is low, `car`, the return stack and both flags keep their values whatever `op` requests.
- R3: `op` = 0 (increment) loads `car + 1`, and the value wraps from 255 to 0.
- R4: `op` = 1 (jump) loads `target` into `car`.
- R5: `op` = 2 (conditional jump) loads `target` when `flags[cond_sel]` is 1, and `car + 1` when it is 0.
- R6: `op` = 3 (call) pushes `car + 1` and loads `target`. `op` = 4 (return) loads the most recently pushed value and removes it, so returns come back in last-in, first-out order over up to 4 nested calls.
- R7: A call made while the stack already holds 4 entries leaves the stack unchanged and loads `car + 1`. It also sets `stk_ovf`, which stays at 1 until reset.
- R8: A return made while the stack is empty loads 0. It also sets `stk_unf`, which stays at 1 until reset.
- R9: `op` = 5 (map) with `map_mode` = 0 loads `{opcode, 4'b0000}`.
- R10: `op` = 5 with `map_mode` = 1 loads `{4'b0000, opcode}`.
- R11: `op` = 5 with `map_mode` = 2 or 3 loads decode-table entry `opcode`. A clock edge with `tbl_we` high writes `tbl_wdata` into entry `tbl_waddr`, whatever the level of `en`.
- R12: `op` = 6 (OR-low) replaces `car[3:0]` with `car[3:0] | target[3:0]` and leaves `car[7:4]` unchanged, whatever `target[7:4]` holds.
- R13: `op` = 7 (unused code) behaves as increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable for the address register |
| op | input | 3 | Next-address operation |
| target | input | 8 | Branch / call target or OR mask |
| cond_sel | input | 3 | Index of the flag tested by a conditional jump |
| flags | input | 8 | Status flags |
| opcode | input | 4 | Current machine-instruction opcode |
| map_mode | input | 2 | Opcode mapping method |
| tbl_we | input | 1 | Decode-table write strobe |
| tbl_waddr | input | 4 | Decode-table entry to write |
| tbl_wdata | input | 8 | Decode-table write data |
| car | output | 8 | Control address register |
| stk_ovf | output | 1 | Sticky return-stack overflow |
| stk_unf | output | 1 | Sticky return-stack underflow |

## Verification
The bench sweeps all 256 register values through the increment. A design that saturates at 255 or leaks a carry fails at the wrap. Every flag index is tested against a one-hot pattern and against the inverted pattern, which exposes a condition mux that is off by one index or inverted in sense. The bench nests calls one level deeper than the stack holds, then returns once more than it called. A stack that overwrites its bottom entry or drops its pointer below zero returns the wrong addresses, and a flag that is not sticky reads back 0. All 16 opcodes are mapped under every mode, and the table is written while `en` is low. The OR-low sweep puts ones in the upper target bits, so a design that ORs the whole target shows changed high bits.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [2:0] {
    NA_INC  = 3'd0,
    NA_JMP  = 3'd1,
    NA_CJMP = 3'd2,
    NA_CALL = 3'd3,
    NA_RET  = 3'd4,
    NA_MAP  = 3'd5,
    NA_ORLO = 3'd6,
    NA_RSV  = 3'd7
  } na_op_e;

  typedef enum logic [1:0] {
    MAP_LOZ  = 2'd0,
    MAP_HIZ  = 2'd1,
    MAP_TBL  = 2'd2,
    MAP_TBL2 = 2'd3
  } map_mode_e;

endpackage

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int AW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top,
  output logic          full,
  output logic          empty
);
  localparam int SPW = $clog2(DEPTH + 1);

  logic [SPW-1:0] sp;
  logic [AW-1:0]  mem [DEPTH];

  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && sp == SPW'(gi)) begin
        mem[gi] <= push_data;
      end
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp == SPW'(i + 1)) top = mem[i];
    end
  end

  p_sp_bound_r6: assert property (@(posedge clk) disable iff (rst)
    sp <= SPW'(DEPTH));

  p_push_top_r6: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (top == $past(push_data)));

  p_full_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> $stable(sp));

  p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (sp == '0));

endmodule

// File: rtl/useq_map_unit.sv
module useq_map_unit
  import useq_pkg::*;
#(
  parameter int AW  = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           tbl_we,
  input  logic [OPW-1:0] tbl_waddr,
  input  logic [AW-1:0]  tbl_wdata,
  input  logic [OPW-1:0] opcode,
  input  logic [1:0]     mode,
  output logic [AW-1:0]  map_addr
);
  localparam int TBLN = 1 << OPW;
  localparam int ZW   = AW - OPW;

  logic [AW-1:0] tbl [TBLN];

  for (genvar gi = 0; gi < TBLN; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (tbl_we && tbl_waddr == OPW'(gi)) tbl[gi] <= tbl_wdata;
    end
  end

  always_comb begin
    case (map_mode_e'(mode))
      MAP_LOZ: map_addr = {opcode, {ZW{1'b0}}};
      MAP_HIZ: map_addr = {{ZW{1'b0}}, opcode};
      default: map_addr = tbl[opcode];
    endcase
  end

  p_tbl_write_r11: assert property (@(posedge clk)
    (tbl_we && mode[1] && opcode == tbl_waddr && !$isunknown(tbl_wdata))
      |=> (mode[1] && opcode == $past(tbl_waddr)) -> (map_addr == $past(tbl_wdata)));

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW    = 8,
  parameter int OPW   = 4,
  parameter int SELW  = 3,
  parameter int DEPTH = 4,
  parameter int ORW   = 4,
  localparam int FLAGW = 1 << SELW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic [AW-1:0]    target,
  input  logic [SELW-1:0]  cond_sel,
  input  logic [FLAGW-1:0] flags,
  input  logic [OPW-1:0]   opcode,
  input  logic [1:0]       map_mode,
  input  logic             tbl_we,
  input  logic [OPW-1:0]   tbl_waddr,
  input  logic [AW-1:0]    tbl_wdata,
  output logic [AW-1:0]    car,
  output logic             stk_ovf,
  output logic             stk_unf
);
  logic [AW-1:0] car_inc, nxt, stk_top, map_addr;
  logic          push, pop, set_ovf, set_unf, full, empty;

  assign car_inc = car + 1'b1;

  useq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(push & en), .pop(pop & en),
    .push_data(car_inc),
    .top(stk_top), .full(full), .empty(empty)
  );

  useq_map_unit #(.AW(AW), .OPW(OPW)) u_map (
    .clk(clk), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .opcode(opcode), .mode(map_mode), .map_addr(map_addr)
  );

  always_comb begin
    nxt     = car_inc;
    push    = 1'b0;
    pop     = 1'b0;
    set_ovf = 1'b0;
    set_unf = 1'b0;
    case (na_op_e'(op))
      NA_JMP:  nxt = target;
      NA_CJMP: nxt = flags[cond_sel] ? target : car_inc;
      NA_CALL: begin
        if (!full) begin
          push = 1'b1;
          nxt  = target;
        end else begin
          set_ovf = 1'b1;
        end
      end
      NA_RET: begin
        if (!empty) begin
          pop = 1'b1;
          nxt = stk_top;
        end else begin
          set_unf = 1'b1;
          nxt     = '0;
        end
      end
      NA_MAP:  nxt = map_addr;
      NA_ORLO: nxt = {car[AW-1:ORW], car[ORW-1:0] | target[ORW-1:0]};
      default: nxt = car_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      car     <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else if (en) begin
      car <= nxt;
      if (set_ovf) stk_ovf <= 1'b1;
      if (set_unf) stk_unf <= 1'b1;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(car));

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd0) |=> (car == AW'($past(car) + 1'b1)));

  p_jmp_r4: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd1) |=> (car == $past(target)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);

  p_unf_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd4 && empty) |=> (car == '0 && stk_unf));

  p_or_high_r12: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd6) |=> (car[AW-1:ORW] == $past(car[AW-1:ORW])));

endmodule

// File: tb/tb_useq_sequencer.sv
module tb_useq_sequencer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] target = '0;
  logic [2:0] cond_sel = '0;
  logic [7:0] flags = '0;
  logic [3:0] opcode = '0;
  logic [1:0] map_mode = '0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_waddr = '0;
  logic [7:0] tbl_wdata = '0;
  logic [7:0] car;
  logic       stk_ovf, stk_unf;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_car;
  logic [7:0] m_stk [4];
  int         m_sp;
  logic       m_ovf, m_unf;
  logic [7:0] m_tbl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_sequencer dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .target(target),
    .cond_sel(cond_sel), .flags(flags), .opcode(opcode), .map_mode(map_mode),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .car(car), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "car", car, m_car);
    chk(tag, "stk_ovf", stk_ovf, m_ovf);
    chk(tag, "stk_unf", stk_unf, m_unf);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0; tbl_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_car = '0; m_sp = 0; m_ovf = 1'b0; m_unf = 1'b0;
    check_all("R1");
  endtask

  // one sequencer cycle: drive after a falling edge, check at the next falling edge
  task automatic step(input logic [2:0] o, input logic [7:0] t, input logic e);
    string tag;
    logic [7:0] inc;
    op = o; target = t; en = e;
    inc = m_car + 8'd1;
    tag = "R3";
    if (!e) tag = "R2";
    else begin
      case (o)
        3'd0: begin tag = "R3"; m_car = inc; end
        3'd1: begin tag = "R4"; m_car = t; end
        3'd2: begin tag = "R5"; m_car = flags[cond_sel] ? t : inc; end
        3'd3: begin
          if (m_sp == 4) begin tag = "R7"; m_ovf = 1'b1; m_car = inc; end
          else begin tag = "R6"; m_stk[m_sp] = inc; m_sp++; m_car = t; end
        end
        3'd4: begin
          if (m_sp == 0) begin tag = "R8"; m_unf = 1'b1; m_car = '0; end
          else begin tag = "R6"; m_sp--; m_car = m_stk[m_sp]; end
        end
        3'd5: begin
          if (map_mode == 2'd0) begin tag = "R9"; m_car = {opcode, 4'h0}; end
          else if (map_mode == 2'd1) begin tag = "R10"; m_car = {4'h0, opcode}; end
          else begin tag = "R11"; m_car = m_tbl[opcode]; end
        end
        3'd6: begin tag = "R12"; m_car = {m_car[7:4], m_car[3:0] | t[3:0]}; end
        default: begin tag = "R13"; m_car = inc; end
      endcase
    end
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic tbl_write(input logic [3:0] a, input logic [7:0] d);
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    op = 3'd1; target = 8'hEE; en = 1'b0;
    m_tbl[a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
    check_all("R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2: disabled cycles do not move the register
    step(3'd1, 8'h5A, 1'b0);
    step(3'd3, 8'h33, 1'b0);
    step(3'd4, 8'h00, 1'b0);

    // R3: increment across every value, including the 255 -> 0 wrap
    for (int v = 0; v < 256; v++) begin
      step(3'd1, 8'(v), 1'b1);
      step(3'd0, 8'h00, 1'b1);
    end

    // R13: unused code increments
    step(3'd1, 8'hFE, 1'b1);
    step(3'd7, 8'h12, 1'b1);
    step(3'd7, 8'h34, 1'b1);

    // R5: every flag index, true and false
    for (int s = 0; s < 8; s++) begin
      cond_sel = 3'(s);
      flags = 8'(1 << s);
      step(3'd1, 8'h40, 1'b1);
      step(3'd2, 8'(8'h80 + s), 1'b1);
      flags = ~8'(1 << s);
      step(3'd1, 8'h40, 1'b1);
      step(3'd2, 8'(8'h80 + s), 1'b1);
    end

    // R6 / R7 / R8: nesting one past capacity, then one return too many
    step(3'd1, 8'h10, 1'b1);
    for (int k = 0; k < 4; k++) step(3'd3, 8'(8'h20 + 16 * k), 1'b1);
    step(3'd3, 8'h90, 1'b1);
    step(3'd0, 8'h00, 1'b1);
    for (int k = 0; k < 5; k++) step(3'd4, 8'h00, 1'b1);
    step(3'd4, 8'h00, 1'b1);

    // R1: reset clears sticky flags and the stack
    do_reset();
    step(3'd3, 8'hA0, 1'b1);
    step(3'd4, 8'h00, 1'b1);

    // R11: load the decode table with en low
    for (int i = 0; i < 16; i++) tbl_write(4'(i), 8'((i * 37 + 5) & 255));

    // R9 / R10 / R11: every opcode under every mode
    for (int m = 0; m < 4; m++) begin
      map_mode = 2'(m);
      for (int c = 0; c < 16; c++) begin
        opcode = 4'(c);
        step(3'd1, 8'h77, 1'b1);
        step(3'd5, 8'h00, 1'b1);
      end
    end

    // R12: OR into the low bits only
    for (int b = 0; b < 4; b++) begin
      for (int t = 0; t < 16; t++) begin
        step(3'd1, (b == 0) ? 8'h00 : (b == 1) ? 8'hA5 : (b == 2) ? 8'h3C : 8'hF0, 1'b1);
        step(3'd6, 8'(8'hF0 | t), 1'b1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule